// File: doc/BRIEF.md
# Bit-serial multiplier over GF(3^m), low digit first

This block forms the product of two elements of the ternary extension field GF(3^m). Each element is a polynomial of degree below m whose coefficients are digits in {0,1,2}. The multiplier consumes one digit of the operand B per clock, starting from the lowest digit. In every cycle it adds that digit times the running multiplicand into an accumulator. It then multiplies the multiplicand by x and folds the overflowing top digit back through the reduction polynomial within the same cycle. A full product therefore takes exactly m cycles, and the storage is one register each for the multiplicand, the multiplier digits and the accumulator, plus a small counter.

The default build has m = 97 and a hard-wired reduction polynomial x^97 + x^16 + 2. In that build each reduction step touches only two digit positions. A parameter selects a generic build instead. It reads the lower coefficients p_0..p_{m-1} of any monic degree-m polynomial from an input and reduces across every digit position. A caller pulses `start` with the operands present. It then waits for the one-cycle `done` pulse and reads the product, which stays put until the next start.

Top module: `gf3m_lse_mul`

## Requirements
- R1: After reset, `done` is 0 and `c_out` is all zero.
- R2: Every field element is carried as m two-bit digits, digit i in bits [2i+1:2i], coded 00 = 0, 01 = 1, 10 = 2. A start pulse loads A and B and clears the accumulator, so in the cycle after start `c_out` is zero.
- R3: `done` rises exactly m clock edges after the edge that samples `start`, and `c_out` then equals A*B mod p(x).
- R4: `done` is high for a single cycle per product.
- R5: While no product is running and `start` is low, `c_out` does not change.
- R6: With GENERIC = 1, reduction uses the coefficients on `poly_in` (digit i = coefficient of x^i, leading x^m coefficient implied as 1).
- R7: With legal operand digits, `c_out` never carries the unused code 11 in any digit.
- R8: A multiplier B that is the constant 0, 1 or 2 gives zero, A, or A with every digit negated (0, A or 2A).
- R9: A start pulse during a running product abandons it; the result and the `done` timing follow the new operands.
- R10: Reduction folds the top digit back. With the fixed polynomial, x^96 times x gives 2x^16 + 1. With p(x) = x^97 + 2x^5 + x + 1 it gives x^5 + 2x + 2.
- R11: With GENERIC = 0, the value on `poly_in` has no effect on the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads operands and begins a product |
| a_in | input | 2*M | Multiplicand A, m packed digits |
| b_in | input | 2*M | Multiplier B, m packed digits |
| poly_in | input | 2*M | Lower coefficients of p(x), used only when GENERIC = 1 |
| c_out | output | 2*M | Accumulator / product C |
| done | output | 1 | One-cycle pulse when C holds the finished product |

## Verification
The checks assume that every digit on `a_in`, `b_in` and `poly_in` uses only the codes 00, 01 and 10. Under that assumption the digit-code property on the product and the ternary adder formulas are sound. The stimulus builds every operand and polynomial from integer digits 0..2 through one encoding function, so the code 11 is never driven. The latency property counts from the most recent start, which also covers a start pulse that arrives during a running product.

// File: rtl/gf3m_pkg.sv
package gf3m_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;

  // negation equals doubling: exchange the two code bits
  function automatic trit_t trit_neg(trit_t d);
    return {d[0], d[1]};
  endfunction

  // sum of two digits mod 3 in the 00/01/10 code
  function automatic trit_t trit_add(trit_t a, trit_t b);
    logic k;
    k = (a[0] | b[1]) ^ (a[1] | b[0]);
    return {(a[0] | b[0]) ^ k, (a[1] | b[1]) ^ k};
  endfunction

  // digit times a scalar in {0,1,2}: drop, pass or swap
  function automatic trit_t trit_scale(trit_t d, trit_t s);
    trit_t r;
    case (s)
      TRIT_ONE: r = d;
      TRIT_TWO: r = trit_neg(d);
      default:  r = TRIT_ZERO;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gf3m_mac.sv
module gf3m_mac
  import gf3m_pkg::*;
#(
  parameter int M = 97,
  localparam int W = 2 * M
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  input  trit_t        dig_i,
  output logic [W-1:0] sum_o
);

  for (genvar i = 0; i < M; i++) begin : g_dig
    assign sum_o[2*i +: 2] = trit_add(acc_i[2*i +: 2], trit_scale(mcand_i[2*i +: 2], dig_i));
  end

endmodule

// File: rtl/gf3m_xtime.sv
module gf3m_xtime
  import gf3m_pkg::*;
#(
  parameter int M       = 97,
  parameter bit GENERIC = 1'b0,
  parameter int FIX_T   = 16,
  parameter int FIX_PT  = 1,
  parameter int FIX_P0  = 2,
  localparam int W = 2 * M
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] poly_i,
  output logic [W-1:0] a_o,
  output logic         fold_o
);

  localparam trit_t PT_TRIT = trit_t'(FIX_PT);
  localparam trit_t P0_TRIT = trit_t'(FIX_P0);

  logic [W-1:0] shifted;
  trit_t        top_dig;
  trit_t        neg_top;

  assign shifted = {a_i[W-3:0], 2'b00};
  assign top_dig = a_i[W-1 -: 2];
  assign neg_top = trit_neg(top_dig);
  assign fold_o  = |top_dig;

  if (GENERIC) begin : g_generic
    for (genvar i = 0; i < M; i++) begin : g_dig
      assign a_o[2*i +: 2] = trit_add(shifted[2*i +: 2], trit_scale(neg_top, poly_i[2*i +: 2]));
    end
  end else begin : g_fixed
    logic unused_poly;
    assign unused_poly = ^poly_i;
    for (genvar i = 0; i < M; i++) begin : g_dig
      if (i == FIX_T) begin : g_mid
        assign a_o[2*i +: 2] = trit_add(shifted[2*i +: 2], trit_scale(neg_top, PT_TRIT));
      end else if (i == 0) begin : g_low
        assign a_o[2*i +: 2] = trit_add(shifted[2*i +: 2], trit_scale(neg_top, P0_TRIT));
      end else begin : g_pass
        assign a_o[2*i +: 2] = shifted[2*i +: 2];
      end
    end
  end

endmodule

// File: rtl/gf3m_seq_ctrl.sv
module gf3m_seq_ctrl #(
  parameter int M = 97,
  localparam int CW = (M > 1) ? $clog2(M) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last,
  output logic done
);

  logic [CW-1:0] cnt_q;

  assign last = busy && (cnt_q == CW'(M - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      busy  <= !last;
      done  <= last;
    end else begin
      done  <= 1'b0;
    end
  end

endmodule

// File: rtl/gf3m_lse_mul.sv
module gf3m_lse_mul
  import gf3m_pkg::*;
#(
  parameter int M       = 97,
  parameter bit GENERIC = 1'b0,
  parameter int FIX_T   = 16,
  parameter int FIX_PT  = 1,
  parameter int FIX_P0  = 2,
  localparam int W = 2 * M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] poly_in,
  output logic [W-1:0] c_out,
  output logic         done
);

  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] mac_sum, a_next;
  logic         busy_w, last_w, fold_w;

  gf3m_seq_ctrl #(.M(M)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy_w),
    .last  (last_w),
    .done  (done)
  );

  gf3m_mac #(.M(M)) mac_i (
    .acc_i   (c_q),
    .mcand_i (a_q),
    .dig_i   (b_q[1:0]),
    .sum_o   (mac_sum)
  );

  gf3m_xtime #(
    .M(M), .GENERIC(GENERIC), .FIX_T(FIX_T), .FIX_PT(FIX_PT), .FIX_P0(FIX_P0)
  ) xtime_i (
    .a_i    (a_q),
    .poly_i (poly_in),
    .a_o    (a_next),
    .fold_o (fold_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (start) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= '0;
    end else if (busy_w) begin
      c_q <= mac_sum;
      a_q <= a_next;
      b_q <= {2'b00, b_q[W-1:2]};
    end
  end

  assign c_out = c_q;

endmodule

// File: rtl/gf3m_lse_mul_chk.sv
module gf3m_lse_mul_chk #(
  parameter int M = 97,
  localparam int W = 2 * M,
  localparam int YW = $clog2(M + 2)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic         last,
  input logic [W-1:0] c_out
);

  logic [YW-1:0] cyc_q;
  logic          armed_q;
  logic          bad_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cyc_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (cyc_q < YW'(M + 1)) cyc_q <= cyc_q + 1'b1;
      if (done) armed_q <= 1'b0;
    end
  end

  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < M; i++) bad_code |= c_out[2*i] & c_out[2*i+1];
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (c_out == '0) && busy); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> armed_q && (cyc_q == YW'(M))); // R3
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n) (last && !start) |=> done); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(c_out)); // R5
  AST_LEGAL_DIGITS: assert property (@(posedge clk) disable iff (!rst_n) !bad_code); // R7

endmodule

bind gf3m_lse_mul gf3m_lse_mul_chk #(.M(M)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .busy  (busy_w),
  .last  (last_w),
  .c_out (c_out)
);

// File: tb/gf3m_lse_mul_tb_top.sv
`timescale 1ns/1ps
module gf3m_lse_mul_tb_top;

  localparam int M = 97;
  localparam int W = 2 * M;
  localparam int NPAT = 6;
  // stimulus table: {seed for A, seed for B}
  localparam int PAT[NPAT][2] = '{'{1, 2}, '{5, 3}, '{7, 11}, '{13, 4}, '{2, 17}, '{19, 23}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0, gpoly = '0;
  logic [W-1:0] c_fix, c_gen;
  logic done_fix, done_gen;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gf3m_lse_mul #(.M(M), .GENERIC(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_drv), .b_in(b_drv),
    .poly_in(gpoly), .c_out(c_fix), .done(done_fix));

  gf3m_lse_mul #(.M(M), .GENERIC(1'b1)) dut_g (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_drv), .b_in(b_drv),
    .poly_in(gpoly), .c_out(c_gen), .done(done_gen));

  function automatic logic [1:0] enc(int d);
    return (d == 2) ? 2'b10 : (d == 1) ? 2'b01 : 2'b00;
  endfunction

  function automatic int dig(logic [W-1:0] v, int i);
    return v[2*i+1] ? 2 : (v[2*i] ? 1 : 0);
  endfunction

  function automatic logic [W-1:0] mk_vec(int seed);
    logic [W-1:0] v;
    for (int i = 0; i < M; i++) v[2*i +: 2] = enc((seed * i * i + 7 * i + seed) % 3);
    return v;
  endfunction

  function automatic logic [W-1:0] one_digit(int pos, int d);
    logic [W-1:0] v;
    v = '0;
    v[2*pos +: 2] = enc(d);
    return v;
  endfunction

  function automatic logic [W-1:0] fixed_low();
    return one_digit(16, 1) | one_digit(0, 2);
  endfunction

  // schoolbook product, then reduction from the top degree down
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p);
    int prod[2*M-1];
    logic [W-1:0] r;
    for (int k = 0; k < 2*M-1; k++) prod[k] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        prod[i+j] = (prod[i+j] + dig(a, i) * dig(b, j)) % 3;
    for (int k = 2*M-2; k >= M; k--) begin
      int c;
      c = prod[k];
      prod[k] = 0;
      if (c != 0)
        for (int i = 0; i < M; i++)
          prod[k-M+i] = (prod[k-M+i] + 3 * 3 - c * dig(p, i)) % 3;
    end
    for (int i = 0; i < M; i++) r[2*i +: 2] = enc(prod[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] neg_vec(logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < M; i++) r[2*i +: 2] = {v[2*i], v[2*i+1]};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    a_drv = a;
    b_drv = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_fix && lat < M + 5) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // full product on both builds, with latency, pulse and hold checks
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int lat;
    logic [W-1:0] ef, eg, hf;
    ef = ref_mul(a, b, fixed_low());
    eg = ref_mul(a, b, gpoly);
    launch(a, b);
    check(c_fix == '0, "R2", "accumulator cleared after start", c_fix, '0);
    wait_done(lat);
    check(lat == M && done_gen, "R3", "done latency", W'(lat), W'(M));
    check(c_fix == ef, req, "fixed-polynomial product", c_fix, ef);
    check(c_gen == eg, "R6", "generic-polynomial product", c_gen, eg);
    hf = c_fix;
    @(negedge clk);
    check(!done_fix && !done_gen, "R4", "done single cycle", W'(done_fix), '0);
    repeat (3) @(negedge clk);
    check(c_fix == hf && c_gen == eg, "R5", "result held", c_fix, hf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] hx, e;
    int lat;
    bit seen;
    gpoly = one_digit(5, 2) | one_digit(1, 1) | one_digit(0, 1);
    repeat (3) @(negedge clk);
    check(!done_fix && c_fix == '0 && c_gen == '0, "R1", "state in reset", c_fix, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_fix && c_fix == '0, "R1", "state after reset", c_fix, '0);

    // table walk; fixed build sees a foreign poly_in (R11)
    for (int p = 0; p < NPAT; p++)
      run_op(mk_vec(PAT[p][0]), mk_vec(PAT[p][1]), "R11");

    // constant multipliers R8
    hx = mk_vec(9);
    launch(hx, '0);
    wait_done(lat);
    check(c_fix == '0 && c_gen == '0, "R8", "times zero", c_fix, '0);
    launch(hx, one_digit(0, 1));
    wait_done(lat);
    check(c_fix == hx && c_gen == hx, "R8", "times one", c_fix, hx);
    launch(hx, one_digit(0, 2));
    wait_done(lat);
    check(c_fix == neg_vec(hx) && c_gen == neg_vec(hx), "R8", "times two", c_fix, neg_vec(hx));

    // reduction fold R10
    launch(one_digit(M-1, 1), one_digit(1, 1));
    wait_done(lat);
    e = one_digit(16, 2) | one_digit(0, 1);
    check(c_fix == e, "R10", "x^96*x fixed", c_fix, e);
    e = one_digit(5, 1) | one_digit(1, 2) | one_digit(0, 2);
    check(c_gen == e, "R10", "x^96*x generic", c_gen, e);

    // generic build fed the fixed polynomial R6
    gpoly = fixed_low();
    run_op(mk_vec(31), mk_vec(29), "R3");

    // restart mid-product R9
    launch(mk_vec(3), mk_vec(8));
    seen = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (done_fix) seen = 1'b1;
    end
    launch(mk_vec(6), mk_vec(14));
    wait_done(lat);
    check(!seen && lat == M, "R9", "restart latency", W'(lat), W'(M));
    e = ref_mul(mk_vec(6), mk_vec(14), fixed_low());
    check(c_fix == e, "R9", "restart result", c_fix, e);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule